// File: doc/BRIEF.md
# SCSI Adapter Interrupt and Status Register Front End

This block is the byte-wide register face of a simple SCSI host adapter. It keeps the status, interrupt-cause, sequence-step and FIFO-flag registers that software inspects after an operation, and it drives one level-sensitive interrupt line. The adapter's internal engine reports a finished operation through a one-cycle event that loads new codes into these registers and raises the line. Software acknowledges by reading the interrupt-cause register.

The block also holds three transfer-count bytes, a command register and a configuration register. The high count byte returns a fixed chip identifier until software first writes it, which lets a driver probe the part. A small set of register-only commands (flush, soft reset, bus reset, selection enable and disable) act on the registers at once. Bus phases, data movement and targets belong to other blocks.

Top module: `scsi_irq_regs`

## Requirements
- R1: `irq` always equals bit 7 (interrupt pending) of the status register. Raising it while already set changes nothing, and with no read, write or event it holds its value.
- R2: A read of address 5 (interrupt cause) returns the value held before the access. In that same cycle the cause register clears to 0x00, status bits 7 and 4 (terminal count) clear, the sequence step becomes 0x04 and `irq` falls.
- R3: Address 2 (count high byte) reads as parameter `CHIP_ID` (default 0x12) until it has been written once after reset. From then on it reads the stored byte, even a stored 0x00.
- R4: A write to any of addresses 0, 1 or 2 clears status bit 4 and leaves the other status bits alone.
- R5: Reset (`rst_n` low) zeroes every register, sets the configuration register (address 8) to 0x07 and forgets the high-byte write.
- R6: Command 0x02 (soft reset) lowers `irq` and leaves every register exactly as R5 does.
- R7: Command 0x03 (bus reset) loads the cause register with 0x80. It raises `irq` only if configuration bit 6 is clear.
- R8: Command 0x01 (flush) loads cause 0x08 and zeroes the sequence step (address 6) and FIFO flags (address 7), with no change to `irq`.
- R9: Command 0x44 (enable selection) clears the cause register with no change to `irq`. Command 0x45 (disable selection) clears it and raises `irq`.
- R10: An event (`ev_valid`) loads status with `ev_status` with bit 7 forced set, and loads cause, sequence step and flags from its inputs. It raises `irq`. The event is applied after any read or write in the same cycle, so its values survive a coinciding cause-register read.
- R11: A command is decoded from bits 6:0 of a write to address 3, and address 3 reads back the whole last byte written. Addresses 4 to 7 are read-only, writes to them and to addresses 9 to 15 are ignored, and addresses 9 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; side effects apply on this cycle |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid while `rd_en` is high |
| ev_valid | input | 1 | Internal completion event |
| ev_status | input | 8 | Status value carried by the event |
| ev_intr | input | 8 | Interrupt cause carried by the event |
| ev_seq | input | 8 | Sequence step carried by the event |
| ev_flags | input | 8 | FIFO flags carried by the event |
| irq | output | 1 | Level interrupt request |

## Verification
The acknowledging read of the cause register and a new completion event can land in the same cycle. A read that loses to the event must neither lose the new interrupt nor return the new cause. The bench drives both strobes together while an earlier interrupt is pending. It expects the old cause on `rdata` that cycle, `irq` still high after the edge, and the event's cause on the next read. Command writes that coincide with a pending interrupt, such as flush and enable selection, are checked the same way for an unchanged line.

// File: rtl/scsi_irq_regs.sv
module scsi_irq_regs #(
  parameter logic [7:0] CHIP_ID   = 8'h12,
  parameter logic [7:0] CFG_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ev_valid,
  input  logic [7:0] ev_status,
  input  logic [7:0] ev_intr,
  input  logic [7:0] ev_seq,
  input  logic [7:0] ev_flags,
  output logic       irq
);
  localparam logic [3:0] A_CNT0 = 4'd0, A_CNT1 = 4'd1, A_CNT2 = 4'd2, A_CMD = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4, A_INT = 4'd5, A_SEQ = 4'd6, A_FLG = 4'd7, A_CFG = 4'd8;
  localparam logic [7:0] ST_PEND = 8'h80, ST_TC = 8'h10;
  localparam logic [7:0] IC_RST = 8'h80, IC_FC = 8'h08;
  localparam logic [7:0] SEQ_DONE = 8'h04;
  localparam int         CFG_NORPT = 6;
  localparam logic [6:0] C_FLUSH = 7'h01, C_SRST = 7'h02, C_BRST = 7'h03;
  localparam logic [6:0] C_ENSEL = 7'h44, C_DISSEL = 7'h45;

  logic [7:0] cnt0, cnt1, cnt2, cmd, stat, intr, seq, flg, cfg;
  logic       hi_wr;
  logic [7:0] n_cnt0, n_cnt1, n_cnt2, n_cmd, n_stat, n_intr, n_seq, n_flg, n_cfg;
  logic       n_hi_wr;

  assign irq = stat[7];

  always_comb begin
    case (addr)
      A_CNT0:  rdata = cnt0;
      A_CNT1:  rdata = cnt1;
      A_CNT2:  rdata = hi_wr ? cnt2 : CHIP_ID;
      A_CMD:   rdata = cmd;
      A_STAT:  rdata = stat;
      A_INT:   rdata = intr;
      A_SEQ:   rdata = seq;
      A_FLG:   rdata = flg;
      A_CFG:   rdata = cfg;
      default: rdata = 8'h00;
    endcase
  end

  always_comb begin
    n_cnt0 = cnt0; n_cnt1 = cnt1; n_cnt2 = cnt2; n_cmd = cmd;
    n_stat = stat; n_intr = intr; n_seq = seq; n_flg = flg; n_cfg = cfg;
    n_hi_wr = hi_wr;
    if (rd_en && addr == A_INT) begin
      n_intr = 8'h00;
      n_stat = n_stat & ~(ST_PEND | ST_TC);
      n_seq  = SEQ_DONE;
    end
    if (wr_en) begin
      case (addr)
        A_CNT0: begin n_cnt0 = wdata; n_stat = n_stat & ~ST_TC; end
        A_CNT1: begin n_cnt1 = wdata; n_stat = n_stat & ~ST_TC; end
        A_CNT2: begin n_cnt2 = wdata; n_hi_wr = 1'b1; n_stat = n_stat & ~ST_TC; end
        A_CFG:  n_cfg = wdata;
        A_CMD: begin
          n_cmd = wdata;
          case (wdata[6:0])
            C_FLUSH: begin n_intr = IC_FC; n_seq = 8'h00; n_flg = 8'h00; end
            C_SRST: begin
              n_cnt0 = 8'h00; n_cnt1 = 8'h00; n_cnt2 = 8'h00; n_cmd = 8'h00;
              n_stat = 8'h00; n_intr = 8'h00; n_seq = 8'h00; n_flg = 8'h00;
              n_cfg = CFG_RESET; n_hi_wr = 1'b0;
            end
            C_BRST: begin
              n_intr = IC_RST;
              if (!cfg[CFG_NORPT]) n_stat = n_stat | ST_PEND;
            end
            C_ENSEL:  n_intr = 8'h00;
            C_DISSEL: begin n_intr = 8'h00; n_stat = n_stat | ST_PEND; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (ev_valid) begin
      n_stat = ev_status | ST_PEND;
      n_intr = ev_intr;
      n_seq  = ev_seq;
      n_flg  = ev_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0 <= 8'h00; cnt1 <= 8'h00; cnt2 <= 8'h00; cmd <= 8'h00;
      stat <= 8'h00; intr <= 8'h00; seq <= 8'h00; flg <= 8'h00;
      cfg <= CFG_RESET; hi_wr <= 1'b0;
    end else begin
      cnt0 <= n_cnt0; cnt1 <= n_cnt1; cnt2 <= n_cnt2; cmd <= n_cmd;
      stat <= n_stat; intr <= n_intr; seq <= n_seq; flg <= n_flg;
      cfg <= n_cfg; hi_wr <= n_hi_wr;
    end
  end
endmodule

// File: rtl/scsi_irq_regs_chk.sv
module scsi_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       ev_valid,
  input logic       irq
);
  logic cmd_wr;
  assign cmd_wr = wr_en && addr == 4'd3;

  a_r10_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> irq);
  a_r2_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd5 && !ev_valid && !cmd_wr) |=> !irq);
  a_r1_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en && !ev_valid) |=> $stable(irq));
  a_r6_soft_reset_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6:0] == 7'h02 && !ev_valid) |=> !irq);
  a_r8_flush_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6:0] == 7'h01 && !ev_valid && !(rd_en && addr == 4'd5)) |=> $stable(irq));
  a_r9_dissel_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6:0] == 7'h45) |=> irq);
endmodule

bind scsi_irq_regs scsi_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .ev_valid(ev_valid), .irq(irq)
);

// File: tb/scsi_irq_regs_bench.sv
module scsi_irq_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, ev_valid = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00, ev_status = 8'h00, ev_intr = 8'h00, ev_seq = 8'h00, ev_flags = 8'h00;
  logic [7:0] rdata;
  logic irq;

  int vectors = 0;
  int errors = 0;
  string tag = "R5";

  int m[16];
  bit mhw;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_irq_regs u_scsi_irq_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_valid(ev_valid), .ev_status(ev_status),
    .ev_intr(ev_intr), .ev_seq(ev_seq), .ev_flags(ev_flags), .irq(irq)
  );

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 0;
    m[8] = 7;
    mhw = 0;
  endtask

  function automatic int model_read(int a);
    if (a == 2 && !mhw) return 'h12;
    if (a > 8) return 0;
    return m[a];
  endfunction

  task automatic model_edge(bit r, bit w, int a, int d, bit e, int es, int ei, int eq, int ef);
    if (r && a == 5) begin
      m[5] = 0;
      m[4] = m[4] & 'h6F;
      m[6] = 4;
    end
    if (w) begin
      if (a <= 2) begin
        m[a] = d;
        m[4] = m[4] & 'hEF;
        if (a == 2) mhw = 1;
      end else if (a == 8) m[8] = d;
      else if (a == 3) begin
        m[3] = d;
        case (d % 128)
          'h01: begin m[5] = 'h08; m[6] = 0; m[7] = 0; end
          'h02: model_reset();
          'h03: begin m[5] = 'h80; if ((m[8] / 64) % 2 == 0) m[4] = m[4] | 'h80; end
          'h44: m[5] = 0;
          'h45: begin m[5] = 0; m[4] = m[4] | 'h80; end
          default: ;
        endcase
      end
    end
    if (e) begin
      m[4] = es | 'h80;
      m[5] = ei; m[6] = eq; m[7] = ef;
    end
  endtask

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit w, int a, int d, bit e = 0,
                      int es = 0, int ei = 0, int eq = 0, int ef = 0);
    rd_en = r; wr_en = w; addr = a[3:0]; wdata = d[7:0];
    ev_valid = e; ev_status = es[7:0]; ev_intr = ei[7:0]; ev_seq = eq[7:0]; ev_flags = ef[7:0];
    #1;
    check("irq", int'(irq), (m[4] / 128) % 2);
    if (r) check($sformatf("rdata@%0d", a), int'(rdata), model_read(a));
    @(posedge clk);
    model_edge(r, w, a, d, e, es, ei, eq, ef);
    @(negedge clk);
    rd_en = 0; wr_en = 0; ev_valid = 0;
  endtask

  task automatic rd(int a); step(1, 0, a, 0); endtask
  task automatic wr(int a, int d); step(0, 1, a, d); endtask
  task automatic ev(int es, int ei, int eq, int ef); step(0, 0, 0, 0, 1, es, ei, eq, ef); endtask
  task automatic idle(); step(0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R5 R11 R3: reset contents of the whole map
    tag = "R5";
    for (int a = 0; a < 16; a++) rd(a);
    idle();
    // R10: event loads registers and raises the line
    tag = "R10";
    ev('h10, 'h10, 'h03, 'h05);
    rd(4); rd(6); rd(7);
    // R1: second raise while pending
    tag = "R1";
    ev('h10, 'h08, 'h02, 'h01);
    idle(); idle();
    rd(4);
    // R2: destructive acknowledge
    tag = "R2";
    rd(5); rd(4); rd(5); rd(6);
    // R4: count writes clear terminal count only
    tag = "R4";
    ev('h13, 'h10, 'h01, 'h00);
    wr(0, 'hA5); rd(4); rd(0);
    ev('h12, 'h10, 'h01, 'h00);
    wr(1, 'h5A); rd(4); rd(1);
    rd(5);
    // R3: identifier until first write
    tag = "R3";
    rd(2); wr(2, 'h34); rd(2); wr(2, 'h00); rd(2);
    // R8: flush
    tag = "R8";
    ev('h00, 'h20, 'h02, 'h07);
    wr(3, 'h01); rd(6); rd(7); rd(5);
    wr(3, 'h81); rd(5);
    // R9: selection enable and disable
    tag = "R9";
    ev('h00, 'h10, 'h00, 'h00);
    wr(3, 'h44); rd(5);
    wr(3, 'h45); idle(); rd(5);
    // R7: bus reset reporting on and off
    tag = "R7";
    wr(3, 'h03); rd(5);
    wr(8, 'h47); wr(3, 'h03); idle(); rd(5); rd(8);
    // R10: acknowledge read collides with a new event
    tag = "R10";
    ev('h00, 'h10, 'h00, 'h00);
    step(1, 0, 5, 0, 1, 'h10, 'h20, 'h03, 'h02);
    idle(); rd(4); rd(5);
    // R11: read-only and unused addresses ignore writes
    tag = "R11";
    ev('h00, 'h10, 'h01, 'h03);
    wr(4, 'h00); wr(5, 'hFF); wr(6, 'h77); wr(7, 'h66); wr(12, 'h99);
    rd(4); rd(6); rd(7); rd(12); rd(15);
    wr(3, 'h80); rd(3);
    rd(5);
    // R6: soft reset with dirty state and pending interrupt
    tag = "R6";
    wr(0, 'h11); wr(2, 'h22); ev('h10, 'h40, 'h05, 'h06);
    wr(3, 'h02);
    for (int a = 0; a < 10; a++) rd(a);
    // R5: hardware reset mid-run
    tag = "R5";
    wr(8, 'h40); wr(2, 'h9C); ev('h00, 'h08, 'h01, 'h01);
    rst_n = 1'b0;
    #1; model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 10; a++) rd(a);
    finish_run();
  end
endmodule